// File: doc/BRIEF.md
# Transmit Buffer Address Entry Segmenter

This block turns a single transmit buffer, given as a 36-bit DMA start address and a byte count, into a short list of address-info entries for a transmit descriptor. Each entry holds a start address and a byte count of at most 2047. The lower 32 address bits and the upper 4 bits are presented as two separate fields. A buffer longer than one entry can hold is cut into consecutive pieces. Each piece starts where the previous one ended, with the full 36-bit sum carried into the high field.

A request is offered with `req_valid` and taken when `req_ready` is high. Entries then leave on a valid/ready stream, and `ent_last` marks the final entry of the packet. A request with a zero byte count is refused with a one-cycle `req_err` pulse and produces no entries. A request that would need more than ten entries (more than 20470 bytes) is refused in the same way.

The controller has three states. IDLE waits for a request and is the only state with `req_ready` high. EMIT presents the current entry. REJECT lasts one cycle and drives `req_err`. The transitions are:
- IDLE→EMIT (accept): a valid request arrives with a length in range.
- IDLE→REJECT (refuse): a valid request arrives with a zero or oversized length.
- REJECT→IDLE (recover): always, after one cycle.
- EMIT→EMIT (advance): a non-final entry is handed over.
- EMIT→IDLE (finish): the final entry is handed over.

Top module: `tx_addr_seg`

## Requirements
- R1: After reset, `req_ready` is 1, and `ent_valid` and `req_err` are 0.
- R2: Every entry carries between 1 and 2047 bytes. Every entry except the final one carries exactly 2047, and the final one carries the remainder, so the entry lengths add up to the request length.
- R3: A request of length L yields ceil(L/2047) entries. A length of exactly 20470 is accepted and yields 10 entries.
- R4: The first entry starts at the request address. Each later entry starts at the previous start plus 2047, computed modulo 2^36.
- R5: `ent_addr_lo` carries address bits 31:0 and `ent_addr_hi` carries bits 35:32, so a carry out of bit 31 shows up in `ent_addr_hi`.
- R6: `ent_last` is 1 on the final entry of a packet and 0 on every other entry. Once the final entry is handed over, `ent_valid` drops in the next cycle.
- R7: A request with length 0 is refused. `req_err` is 1 for exactly one cycle, starting in the cycle after the request is taken, and no entry is produced.
- R8: A request with length above 20470 is refused in the same way as R7.
- R9: While `ent_valid` is 1 and `ent_ready` is 0, the presented entry (address, length, last) holds its value.
- R10: `req_ready` is 0 from the cycle after a request is taken until the final entry has been handed over, and during the refusal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 36 | Buffer start address |
| req_len | input | 16 | Buffer length in bytes |
| ent_valid | output | 1 | Entry presented |
| ent_ready | input | 1 | Consumer takes the entry |
| ent_addr_lo | output | 32 | Entry start address bits 31:0 |
| ent_addr_hi | output | 4 | Entry start address bits 35:32 |
| ent_len | output | 11 | Entry byte count |
| ent_last | output | 1 | Final entry of the packet |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume that the consumer follows the valid/ready rule. They also assume that a request's address and length are looked at only in the cycle it is taken, so a requester may change them freely once `req_ready` drops. The stimulus drives requests and `ent_ready` only on the falling clock edge. It drops `req_valid` right after acceptance and holds `ent_ready` low only as a deliberate stall, so every handshake happens at a known rising edge. Lengths cover one entry, the exact 2047 boundary, crossings of bit 32, the 20470 ceiling, and values just past it.

// File: rtl/tx_seg_pkg.sv
package tx_seg_pkg;
    localparam int ADDR_W = 36;
    localparam int LO_W   = 32;
    localparam int HI_W   = ADDR_W - LO_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_REJECT = 2'd2
    } seg_state_e;
endpackage

// File: rtl/seg_len_check.sv
module seg_len_check #(
    parameter int LEN_W   = 16,
    parameter int SEG_MAX = 2047,
    parameter int MAX_ENT = 10
) (
    input  logic [LEN_W-1:0] len,
    output logic             refuse
);
    localparam logic [31:0] TOTAL_MAX = 32'(SEG_MAX * MAX_ENT);

    always_comb begin
        refuse = (len == '0) || (32'(len) > TOTAL_MAX);
    end
endmodule

// File: rtl/seg_step.sv
module seg_step
    import tx_seg_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int ENT_W   = 11,
    parameter int SEG_MAX = 2047
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ENT_W-1:0]  cur_len,
    output logic              is_last
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_len;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(SEG_MAX);
            remain   <= remain - LEN_W'(SEG_MAX);
        end
    end

    always_comb begin
        is_last = (32'(remain) <= 32'(SEG_MAX));
        cur_len = is_last ? remain[ENT_W-1:0] : ENT_W'(SEG_MAX);
    end
endmodule

// File: rtl/tx_addr_seg.sv
module tx_addr_seg
    import tx_seg_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int ENT_W   = 11,
    parameter int MAX_ENT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [35:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              ent_valid,
    input  logic              ent_ready,
    output logic [31:0]       ent_addr_lo,
    output logic [3:0]        ent_addr_hi,
    output logic [ENT_W-1:0]  ent_len,
    output logic              ent_last,
    output logic              req_err
);
    localparam int SEG_MAX = (1 << ENT_W) - 1;
    localparam int CNT_W   = $clog2(MAX_ENT + 1);

    seg_state_e state, state_nx;
    logic       refuse;
    logic       take_req;
    logic       take_ent;
    logic [ADDR_W-1:0] cur_addr;

    seg_len_check #(.LEN_W(LEN_W), .SEG_MAX(SEG_MAX), .MAX_ENT(MAX_ENT)) u_chk (
        .len    (req_len),
        .refuse (refuse)
    );

    seg_step #(.LEN_W(LEN_W), .ENT_W(ENT_W), .SEG_MAX(SEG_MAX)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_req && !refuse),
        .step      (take_ent),
        .load_addr (req_addr),
        .load_len  (req_len),
        .cur_addr  (cur_addr),
        .cur_len   (ent_len),
        .is_last   (ent_last)
    );

    assign take_req = req_valid && req_ready;
    assign take_ent = ent_valid && ent_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take_req) state_nx = refuse ? ST_REJECT : ST_EMIT;
            ST_EMIT:   if (take_ent && ent_last) state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = (state == ST_IDLE);
        ent_valid   = (state == ST_EMIT);
        req_err     = (state == ST_REJECT);
        ent_addr_lo = cur_addr[LO_W-1:0];
        ent_addr_hi = cur_addr[ADDR_W-1:LO_W];
    end

    // entries handed over in the current packet, assertion support only
    logic [CNT_W-1:0] sent_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || take_req) sent_cnt <= '0;
        else if (take_ent)      sent_cnt <= sent_cnt + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> req_ready && !ent_valid && !req_err);

    // R2
    entry_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> (ent_len != '0) && (ent_last || 32'(ent_len) == 32'(SEG_MAX)));

    // R3
    entry_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> 32'(sent_cnt) < 32'(MAX_ENT));

    // R4
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_ent && !ent_last |=>
            {ent_addr_hi, ent_addr_lo} == $past({ent_addr_hi, ent_addr_lo}) + 36'(SEG_MAX));

    // R6
    last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_ent && ent_last |=> !ent_valid);

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !ent_valid && !req_ready && $past(take_req));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && !ent_ready |=>
            ent_valid && $stable(ent_addr_lo) && $stable(ent_addr_hi)
            && $stable(ent_len) && $stable(ent_last));

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ent_valid && !req_err);
endmodule

// File: tb/tx_addr_seg_test.sv
module tx_addr_seg_test;
    localparam int NV = 6;
    localparam int SEGM = 2047;

    localparam logic [35:0] V_ADDR [NV] = '{
        36'h0_0000_1000, 36'h0_1234_5678, 36'h0_0000_0000,
        36'h0_FFFF_FC00, 36'hA_0000_0010, 36'hF_FFFF_F000 };
    localparam logic [15:0] V_LEN [NV] = '{
        16'd1, 16'd2047, 16'd2048, 16'd3000, 16'd20470, 16'd5000 };
    localparam int V_CNT [NV] = '{ 1, 1, 2, 2, 10, 3 };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [35:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        ent_valid;
    logic        ent_ready = 1;
    logic [31:0] ent_addr_lo;
    logic [3:0]  ent_addr_hi;
    logic [10:0] ent_len;
    logic        ent_last;
    logic        req_err;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    tx_addr_seg uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .ent_valid(ent_valid), .ent_ready(ent_ready),
        .ent_addr_lo(ent_addr_lo), .ent_addr_hi(ent_addr_hi),
        .ent_len(ent_len), .ent_last(ent_last),
        .req_err(req_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_ok(input logic [35:0] a, input logic [15:0] l, input int cnt, input bit stall);
        int total = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_len = l; ent_ready = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R10 ready low while emitting", 64'(req_ready), 64'd0);
        for (int i = 0; i < cnt; i++) begin
            logic [35:0] ea = a + 36'(i * SEGM);
            logic [10:0] el = (i == cnt - 1) ? 11'(int'(l) - i * SEGM) : 11'(SEGM);
            chk("R3 entry present", 64'(ent_valid), 64'd1);
            chk("R4 entry address lo", 64'(ent_addr_lo), 64'(ea[31:0]));
            chk("R5 entry address hi", 64'(ent_addr_hi), 64'(ea[35:32]));
            chk("R2 entry length", 64'(ent_len), 64'(el));
            chk("R6 last flag", 64'(ent_last), 64'(i == cnt - 1));
            total += int'(ent_len);
            if (stall && i == 0) begin
                ent_ready = 0;
                @(negedge clk);
                chk("R9 held address", 64'(ent_addr_lo), 64'(ea[31:0]));
                chk("R9 held length", 64'(ent_len), 64'(el));
                chk("R9 still valid", 64'(ent_valid), 64'd1);
                chk("R10 ready low under stall", 64'(req_ready), 64'd0);
                ent_ready = 1;
            end
            @(negedge clk);
        end
        chk("R2 length sum", 64'(total), 64'(l));
        chk("R6 valid drops after last", 64'(ent_valid), 64'd0);
        chk("R10 ready back", 64'(req_ready), 64'd1);
    endtask

    task automatic run_bad(input logic [15:0] l, input string tag);
        @(negedge clk);
        req_valid = 1; req_addr = 36'h5_0000_0000; req_len = l;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " err pulse"}, 64'(req_err), 64'd1);
        chk({tag, " no entry"}, 64'(ent_valid), 64'd0);
        chk("R10 ready low in refusal", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk({tag, " err one cycle"}, 64'(req_err), 64'd0);
        chk({tag, " still no entry"}, 64'(ent_valid), 64'd0);
        chk({tag, " ready back"}, 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset valid", 64'(ent_valid), 64'd0);
        chk("R1 reset err", 64'(req_err), 64'd0);
        rst_n = 1;
        for (int v = 0; v < NV; v++) run_ok(V_ADDR[v], V_LEN[v], V_CNT[v], v == 3);
        run_bad(16'd0, "R7 zero length");
        run_bad(16'd20471, "R8 just over ceiling");
        run_bad(16'd65535, "R8 largest length");
        // R3 ceiling again, with a stall, after refusals
        run_ok(36'h7_FFFF_F800, 16'd20470, 10, 1'b1);
        // R5 carry out of bit 31 on the second entry
        run_ok(36'h3_FFFF_FFFF, 16'd4000, 2, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule